// File: doc/BRIEF.md
# Overlapping Window Assembler for a Three-Tap Stencil

This block sits between a wide input stream and an unrolled one-dimensional stencil datapath. Each accepted input beat brings four 32-bit array elements. The block keeps eight element registers and presents a six-element window. A three-tap filter uses this window to compute four outputs in parallel. Consecutive windows share two elements. Those shared elements stay in the registers, so each array element crosses the input interface only once.

The first window needs two beats. No window is shown until both beats have arrived, so the datapath sees the same kind of window every time. After a window is taken, the lower half of the registers receives the upper half, and the next beat fills the upper half. A window counter marks the last window of a stream. After that window is taken, the block drops back to its empty state, ready for the next stream. Both sides use a valid/ready handshake.

Top module: `smart_window_buf`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Window k of a stream holds stream elements 4k..4k+5. Window element i sits at `out_win` bits [32i+31:32i]. Beat b carries stream elements 4b..4b+3, with element j at `in_beat` bits [32j+31:32j].
- R3: `out_valid` rises only in the cycle after an input beat was accepted. The first window of a stream appears only once two beats have been accepted.
- R4: Elements 0 and 1 of window k equal elements 4 and 5 of window k-1 in the same stream.
- R5: While `out_valid` is 1 and `out_ready` is 0, in the next cycle `out_valid` stays 1 and `out_win` is unchanged.
- R6: `in_ready` is 0 when a window is valid and not being taken, and 1 whenever no window is valid.
- R7: A stream of NUM_WIN windows takes exactly NUM_WIN+1 beats. No window appears beyond the NUM_WIN expected windows.
- R8: `out_last` is 1 exactly on window NUM_WIN-1. In the cycle after that window is taken, `out_valid` is 0.
- R9: Gaps in `in_valid` and random back-pressure on `out_ready` lose no data and reorder nothing.
- R10: A synchronous reset in mid-stream discards the partial state. `out_valid` then stays 0 until two new beats are accepted.
- R11: The first beat of the next stream can be accepted in the same cycle as the last window of the current stream is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block accepts the beat this cycle |
| in_beat | input | 128 | Four 32-bit elements; element j in bits [32j+31:32j] |
| out_valid | output | 1 | A full window is presented |
| out_ready | input | 1 | Datapath takes the window this cycle |
| out_win | output | 192 | Six 32-bit elements; element i in bits [32i+31:32i] |
| out_last | output | 1 | Presented window is the last one of the stream |

## Verification
The hardest case to reach is the hand-over between streams. The final window of one stream must be taken in the very cycle the first beat of the next stream is accepted. In that cycle the beat goes into the lower half instead of the upper half. To create this case, the bench sends streams back to back with no idle beat between them and holds `out_ready` high during that phase, so the boundary cycles line up. The bench counts how often the overlap happens. Random valid gaps and random back-pressure in other phases also exercise the shift-without-load path and the stall path.

// File: rtl/sw_pkg.sv
package sw_pkg;
   typedef enum logic [1:0] {
      FILL_EMPTY = 2'd0,
      FILL_HALF  = 2'd1,
      FILL_FULL  = 2'd2
   } fill_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sw_fill_ctrl.sv
module sw_fill_ctrl
   import sw_pkg::*;
#(
   parameter int unsigned NUM_WIN = 25
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic out_ready,
   output logic in_ready,
   output logic out_valid,
   output logic out_last,
   output logic shift_en,
   output logic load_lo,
   output logic load_hi
);
   localparam int unsigned CNT_W = cnt_width(NUM_WIN);

   fill_t fill_q, post_fill, fill_d;
   logic  out_fire, in_fire, is_last;

   generate
      if (NUM_WIN == 1) begin : g_single
         assign is_last = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (out_fire)
               cnt_q <= is_last ? '0 : cnt_q + 1'b1;
         end
         assign is_last = (cnt_q == CNT_W'(NUM_WIN - 1));
      end
   endgenerate

   assign out_valid = (fill_q == FILL_FULL);
   assign out_last  = out_valid & is_last;
   assign out_fire  = out_valid & out_ready;

   always_comb begin
      if (out_fire)
         post_fill = is_last ? FILL_EMPTY : FILL_HALF;
      else
         post_fill = fill_q;
   end

   assign in_ready = (post_fill != FILL_FULL);
   assign in_fire  = in_valid & in_ready;
   assign shift_en = out_fire & ~is_last;
   assign load_lo  = in_fire & (post_fill == FILL_EMPTY);
   assign load_hi  = in_fire & (post_fill == FILL_HALF);

   always_comb begin
      fill_d = post_fill;
      if (in_fire) begin
         case (post_fill)
            FILL_EMPTY: fill_d = FILL_HALF;
            FILL_HALF:  fill_d = FILL_FULL;
            default:    fill_d = post_fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) fill_q <= FILL_EMPTY;
      else     fill_q <= fill_d;
   end
endmodule

// File: rtl/sw_reg_array.sv
module sw_reg_array #(
   parameter int unsigned ELEM_W  = 32,
   parameter int unsigned BEAT_N  = 4,
   parameter int unsigned OVERLAP = 2
) (
   input  logic                              clk,
   input  logic                              shift_en,
   input  logic                              load_lo,
   input  logic                              load_hi,
   input  logic [BEAT_N*ELEM_W-1:0]          beat_in,
   output logic [(BEAT_N+OVERLAP)*ELEM_W-1:0] win_out
);
   localparam int unsigned REG_N = 2 * BEAT_N;
   localparam int unsigned WIN_N = BEAT_N + OVERLAP;

   logic [ELEM_W-1:0] slot_q [REG_N];

   genvar j;
   generate
      for (j = 0; j < BEAT_N; j++) begin : g_slot
         always_ff @(posedge clk) begin
            if (load_lo)
               slot_q[j] <= beat_in[j*ELEM_W +: ELEM_W];
            else if (shift_en)
               slot_q[j] <= slot_q[j+BEAT_N];
         end
         always_ff @(posedge clk) begin
            if (load_hi)
               slot_q[j+BEAT_N] <= beat_in[j*ELEM_W +: ELEM_W];
         end
      end
      for (j = 0; j < WIN_N; j++) begin : g_win
         assign win_out[j*ELEM_W +: ELEM_W] = slot_q[j];
      end
   endgenerate
endmodule

// File: rtl/smart_window_buf.sv
module smart_window_buf #(
   parameter int unsigned ELEM_W  = 32,
   parameter int unsigned BEAT_N  = 4,
   parameter int unsigned OVERLAP = 2,
   parameter int unsigned NUM_WIN = 25
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              in_valid,
   output logic                              in_ready,
   input  logic [BEAT_N*ELEM_W-1:0]          in_beat,
   output logic                              out_valid,
   input  logic                              out_ready,
   output logic [(BEAT_N+OVERLAP)*ELEM_W-1:0] out_win,
   output logic                              out_last
);
   localparam int unsigned WIN_N = BEAT_N + OVERLAP;

   generate
      if (OVERLAP > BEAT_N) begin : g_bad_overlap
         $error("OVERLAP must not exceed BEAT_N");
      end
      if (NUM_WIN < 1) begin : g_bad_count
         $error("NUM_WIN must be at least 1");
      end
      if (ELEM_W < 1) begin : g_bad_width
         $error("ELEM_W must be at least 1");
      end
   endgenerate

   logic shift_en, load_lo, load_hi;

   sw_fill_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_last  (out_last),
      .shift_en  (shift_en),
      .load_lo   (load_lo),
      .load_hi   (load_hi)
   );

   sw_reg_array #(.ELEM_W(ELEM_W), .BEAT_N(BEAT_N), .OVERLAP(OVERLAP)) u_regs (
      .clk      (clk),
      .shift_en (shift_en),
      .load_lo  (load_lo),
      .load_hi  (load_hi),
      .beat_in  (in_beat),
      .win_out  (out_win)
   );
endmodule

// File: rtl/sw_window_chk.sv
module sw_window_chk #(
   parameter int unsigned ELEM_W = 32,
   parameter int unsigned WIN_N  = 6
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic                    out_last,
   input logic [WIN_N*ELEM_W-1:0] out_win
);
   // R1: reset leaves the block empty and accepting
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready));

   // R3: a window appears only right after a beat is accepted
   assert_fill_before_window_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   // R5: a stalled window holds still
   assert_stall_stable_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_win)));

   // R6: back-pressure reaches the input side
   assert_backpressure_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   // R6: an empty or half-filled block always accepts
   assert_accept_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

   // R8: after the last window is taken the block is empty
   assert_empty_after_last_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind smart_window_buf sw_window_chk #(.ELEM_W(ELEM_W), .WIN_N(BEAT_N + OVERLAP)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_last  (out_last),
   .out_win   (out_win)
);

// File: tb/smart_window_buf_tb.sv
module smart_window_buf_tb;
   localparam int unsigned ELEM_W  = 32;
   localparam int unsigned BEAT_N  = 4;
   localparam int unsigned OVERLAP = 2;
   localparam int unsigned NUM_WIN = 6;
   localparam int unsigned WIN_N   = BEAT_N + OVERLAP;
   localparam int unsigned BEAT_W  = BEAT_N * ELEM_W;
   localparam int unsigned WIN_W   = WIN_N * ELEM_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [BEAT_W-1:0] in_beat = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [WIN_W-1:0]  out_win;
   logic              out_last;

   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;
   bit rdy_rand = 1'b0;
   int b2b_hits = 0;

   logic [WIN_W-1:0] exp_q[$];
   bit               last_q[$];

   always #4 clk = ~clk;

   smart_window_buf #(.ELEM_W(ELEM_W), .BEAT_N(BEAT_N), .OVERLAP(OVERLAP), .NUM_WIN(NUM_WIN)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_beat   (in_beat),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_win   (out_win),
      .out_last  (out_last)
   );

   task automatic check(input bit ok, input string req, input logic [WIN_W-1:0] act,
                        input logic [WIN_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // Driver: present one beat, return once it is accepted at the next edge
   task automatic send_beat(input logic [BEAT_W-1:0] d, input int gap);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_beat  = d;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [BEAT_W-1:0] make_beat(input int unsigned base, input int b);
      logic [BEAT_W-1:0] r;
      for (int j = 0; j < BEAT_N; j++)
         r[j*ELEM_W +: ELEM_W] = ELEM_W'(base + BEAT_N*b + j);
      return r;
   endfunction

   task automatic send_stream(input int unsigned base, input int max_gap);
      logic [WIN_W-1:0] w;
      for (int k = 0; k < NUM_WIN; k++) begin
         for (int i = 0; i < WIN_N; i++)
            w[i*ELEM_W +: ELEM_W] = ELEM_W'(base + BEAT_N*k + i);
         exp_q.push_back(w);
         last_q.push_back(k == NUM_WIN - 1);
      end
      for (int b = 0; b <= NUM_WIN; b++)
         send_beat(make_beat(base, b), (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0);
   endtask

   task automatic drain_and_check();
      int t = 0;
      go_idle();
      while (exp_q.size() != 0 && t < 2000) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(negedge clk);
      #2;
      check(exp_q.size() == 0, "R9 all windows delivered", WIN_W'(exp_q.size()), '0);
      check(out_valid == 1'b0, "R7 no window beyond stream", WIN_W'(out_valid), '0);
   endtask

   // Monitor / scoreboard
   initial begin
      logic [WIN_W-1:0] prev_win;
      logic [WIN_W-1:0] stall_win;
      logic [WIN_W-1:0] exp;
      bit               lst;
      bit               first = 1'b1;
      bit               stalled = 1'b0;
      forever begin
         @(negedge clk);
         out_ready = mon_en && (rdy_rand ? ($urandom % 3 != 0) : 1'b1);
         #1;
         if (!mon_en || rst) begin
            stalled = 1'b0;
            first   = 1'b1;
         end else begin
            if (stalled) begin
               check(out_valid && out_win == stall_win, "R5 stalled window stable", out_win, stall_win);
            end
            if (out_valid && !out_ready)
               check(in_ready == 1'b0, "R6 input blocked while stalled", WIN_W'(in_ready), '0);
            if (!out_valid)
               check(in_ready == 1'b1, "R6 input open while not full", WIN_W'(in_ready), WIN_W'(1));
            stalled   = out_valid && !out_ready;
            stall_win = out_win;
            if (out_valid && out_ready) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R7 unexpected extra window", out_win, '0);
               end else begin
                  exp = exp_q.pop_front();
                  lst = last_q.pop_front();
                  check(out_win == exp, "R2 window contents", out_win, exp);
                  check(out_last == lst, "R8 last flag", WIN_W'(out_last), WIN_W'(lst));
                  if (!first)
                     check(out_win[OVERLAP*ELEM_W-1:0] == prev_win[BEAT_N*ELEM_W +: OVERLAP*ELEM_W],
                           "R4 reused overlap", WIN_W'(out_win[OVERLAP*ELEM_W-1:0]),
                           WIN_W'(prev_win[BEAT_N*ELEM_W +: OVERLAP*ELEM_W]));
                  first    = lst;
                  prev_win = out_win;
                  if (lst && in_valid && in_ready) b2b_hits++;
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check(out_valid == 1'b0, "R1 out_valid after reset", WIN_W'(out_valid), '0);
      check(in_ready == 1'b1, "R1 in_ready after reset", WIN_W'(in_ready), WIN_W'(1));
      @(negedge clk);
      rst = 1'b0;

      // R3: one beat is not enough for a window
      send_beat(make_beat(32'h1000, 0), 0);
      go_idle();
      #2;
      check(out_valid == 1'b0, "R3 no window after one beat", WIN_W'(out_valid), '0);
      send_beat(make_beat(32'h1000, 1), 0);
      go_idle();
      #2;
      check(out_valid == 1'b1, "R3 window after two beats", WIN_W'(out_valid), WIN_W'(1));
      check(out_win == {make_beat(32'h1000, 1)[OVERLAP*ELEM_W-1:0], make_beat(32'h1000, 0)},
            "R2 first window", out_win, {make_beat(32'h1000, 1)[OVERLAP*ELEM_W-1:0], make_beat(32'h1000, 0)});

      // R10: reset in mid-stream, then two fresh beats are needed
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #2;
      check(out_valid == 1'b0, "R10 cleared by reset", WIN_W'(out_valid), '0);
      send_beat(make_beat(32'h2000, 0), 0);
      go_idle();
      #2;
      check(out_valid == 1'b0, "R10 one beat after reset", WIN_W'(out_valid), '0);
      send_beat(make_beat(32'h2000, 1), 0);
      go_idle();
      #2;
      check(out_valid == 1'b1, "R10 window after two beats", WIN_W'(out_valid), WIN_W'(1));
      check(out_win[ELEM_W-1:0] == 32'h2000, "R10 fresh data", WIN_W'(out_win[ELEM_W-1:0]), WIN_W'(32'h2000));
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;

      // R2 R7: plain stream, always ready
      mon_en = 1'b1;
      send_stream(32'h0001_0000, 0);
      drain_and_check();

      // R9: input gaps and random back-pressure
      rdy_rand = 1'b1;
      send_stream(32'h0002_0000, 3);
      drain_and_check();
      send_stream(32'h0003_0000, 1);
      drain_and_check();

      // R11: streams back to back, always ready
      rdy_rand = 1'b0;
      send_stream(32'h0004_0000, 0);
      send_stream(32'h0005_0000, 0);
      send_stream(32'h0006_0000, 0);
      drain_and_check();
      check(b2b_hits > 0, "R11 next stream accepted with last window",
            WIN_W'(b2b_hits), WIN_W'(1));

      // R5 R6: heavy back-pressure with back-to-back streams
      rdy_rand = 1'b1;
      send_stream(32'h0007_0000, 0);
      send_stream(32'h0008_0000, 2);
      drain_and_check();

      summary();
      $finish;
   end
endmodule